// File: doc/BRIEF.md
# Bus Power Leakage Model

This block estimates the data-dependent supply current drawn by an internal 8-bit bus, one estimate per accepted bus value. A harness streams the successive values seen on the bus, each marked by a valid strobe. The block turns each value into a leakage count and then into a scaled sample that a downstream power-analysis engine can consume as a synthetic trace. Analog effects, noise and acquisition are not modelled.

Two leakage models are available, chosen per sample by a mode input. In the precharged model every line starts high, so each zero bit driven onto the bus discharges one line and is counted. In the switching model the count is the number of lines that toggle from the last accepted bus value to the new one. A memory read is therefore fed as two back-to-back samples, the address followed by the fetched data byte. The switching count of the data phase then shows how many lines changed from address to data. The count is converted to a sample with a linear rule: a configurable offset plus a configurable step per counted bit.

Top module: `busleak_model`

## Requirements
- R1: After reset `out_valid` is 0, `out_count` is 0, `out_sample` is 0 and the stored previous bus value is all zeros.
- R2: With `in_mode` = 0 (precharged model) on an accepted sample, `out_count` equals the number of 0 bits in `in_bus`.
- R3: With `in_mode` = 1 (switching model) on an accepted sample, `out_count` equals the number of bit positions in which `in_bus` differs from the previous accepted bus value.
- R4: The first accepted sample after reset compares against the all-zeros previous value, so in the switching model its count is the number of 1 bits in `in_bus`.
- R5: `out_sample` equals `cfg_offset + cfg_step * out_count` as an unsigned value, with both configuration inputs taken in the accepting cycle; when that sum exceeds 16'hFFFF the sample is 16'hFFFF.
- R6: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, so results arrive one cycle after acceptance and back-to-back samples give back-to-back results.
- R7: While `in_valid` is low, `in_bus`, `in_mode` and the configuration inputs have no effect: `out_count` and `out_sample` hold, and the previous bus value is not updated.
- R8: Every accepted sample becomes the previous value in either mode, so a switching sample that follows a precharged sample compares against that precharged sample's bus value.
- R9: A read modelled as an address sample followed by a data sample in switching mode yields, for the data sample, the number of bits that differ between address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_bus`, `in_mode` and the configuration inputs |
| in_bus | input | 8 | Value driven onto the modelled bus |
| in_mode | input | 1 | 0 = precharged (count zeros), 1 = switching (count toggles) |
| cfg_offset | input | 16 | Fixed offset added to every sample |
| cfg_step | input | 8 | Increment per counted bit |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_count | output | 4 | Leakage count of the last accepted sample |
| out_sample | output | 16 | Scaled leakage sample, saturating |

## Verification
The assertions assume that `in_valid` is a clean level sampled at the rising edge and that reset is asserted at start-up before any sample is offered; they assume nothing about how configuration values change between samples. The bench drives every input only on falling edges, holds `in_valid` low throughout reset, and varies mode, offset and step freely between samples including during idle gaps. Sweeps cover all 256 bus values in the precharged model and a dense grid of previous/new pairs in the switching model, with offsets and steps chosen both to stay in range and to hit the saturation limit exactly and past it.

// File: rtl/busleak_pkg.sv
package busleak_pkg;

    typedef enum logic {
        LEAK_PRECHARGE = 1'b0,
        LEAK_SWITCH    = 1'b1
    } leak_mode_e;

    function automatic int unsigned cnt_width(input int unsigned bits);
        return $clog2(bits + 1);
    endfunction

endpackage

// File: rtl/busleak_popcnt.sv
module busleak_popcnt #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CNT_W'(vec_i[i]);
        end
    end

endmodule

// File: rtl/busleak_select.sv
module busleak_select
    import busleak_pkg::*;
#(
    parameter int unsigned BUS_W = 8,
    parameter int unsigned CNT_W = $clog2(BUS_W + 1)
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [BUS_W-1:0] prev_i,
    input  leak_mode_e       mode_i,
    output logic [CNT_W-1:0] count_o
);

    logic [BUS_W-1:0] event_vec;

    // Per-line event: a discharge in the precharged model, a toggle in the switching model.
    for (genvar b = 0; b < BUS_W; b++) begin : g_line
        always_comb begin
            if (mode_i == LEAK_SWITCH) begin
                event_vec[b] = bus_i[b] ^ prev_i[b];
            end else begin
                event_vec[b] = ~bus_i[b];
            end
        end
    end

    busleak_popcnt #(
        .W     (BUS_W),
        .CNT_W (CNT_W)
    ) u_popcnt (
        .vec_i   (event_vec),
        .count_o (count_o)
    );

endmodule

// File: rtl/busleak_scale.sv
module busleak_scale #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned STEP_W = 8,
    parameter int unsigned OUT_W  = 16
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [OUT_W-1:0]  offset_i,
    output logic [OUT_W-1:0]  sample_o
);

    localparam int unsigned PROD_W = CNT_W + STEP_W;
    localparam int unsigned SUM_W  = ((OUT_W > PROD_W) ? OUT_W : PROD_W) + 1;

    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        prod = PROD_W'(step_i) * PROD_W'(count_i);
        sum  = SUM_W'(offset_i) + SUM_W'(prod);
        if (|sum[SUM_W-1:OUT_W]) begin
            sample_o = '1;
        end else begin
            sample_o = sum[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/busleak_model.sv
module busleak_model
    import busleak_pkg::*;
#(
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned STEP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [BUS_W-1:0]              in_bus,
    input  logic                          in_mode,
    input  logic [OUT_W-1:0]              cfg_offset,
    input  logic [STEP_W-1:0]             cfg_step,
    output logic                          out_valid,
    output logic [$clog2(BUS_W+1)-1:0]    out_count,
    output logic [OUT_W-1:0]              out_sample
);

    localparam int unsigned CNT_W = $clog2(BUS_W + 1);

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] smp;
        logic [BUS_W-1:0] prev;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] cnt_w;
    logic [OUT_W-1:0] smp_w;
    leak_mode_e       mode_w;

    assign mode_w = leak_mode_e'(in_mode);

    busleak_select #(
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) u_select (
        .bus_i   (in_bus),
        .prev_i  (st_q.prev),
        .mode_i  (mode_w),
        .count_o (cnt_w)
    );

    busleak_scale #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W),
        .OUT_W  (OUT_W)
    ) u_scale (
        .count_i  (cnt_w),
        .step_i   (cfg_step),
        .offset_i (cfg_offset),
        .sample_o (smp_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cnt  = cnt_w;
            st_d.smp  = smp_w;
            st_d.prev = in_bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_count  = st_q.cnt;
    assign out_sample = st_q.smp;

    // R6: result strobe trails the input strobe by exactly one cycle
    p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R7: idle cycles leave the published sample and count untouched
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sample) && $stable(out_count)));

    // R7: idle cycles leave the bus history untouched
    p_prev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.prev));

    // R5: a sample never wraps below the offset it was built on
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sample >= $past(cfg_offset)));

    // R2: counts stay within the bus width
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(BUS_W));

endmodule

// File: tb/busleak_model_bench.sv
module busleak_model_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_bus = '0;
    logic        in_mode = 1'b0;
    logic [15:0] cfg_offset = '0;
    logic [7:0]  cfg_step = '0;
    logic        out_valid;
    logic [3:0]  out_count;
    logic [15:0] out_sample;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busleak_model u_busleak_model (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bus     (in_bus),
        .in_mode    (in_mode),
        .cfg_offset (cfg_offset),
        .cfg_step   (cfg_step),
        .out_valid  (out_valid),
        .out_count  (out_count),
        .out_sample (out_sample)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sample(input int off, input int stp, input int cnt);
        int s;
        s = off + stp * cnt;
        return (s > 65535) ? 65535 : s;
    endfunction

    // Called at a falling edge: offers one sample, checks its result one edge later.
    task automatic send(input string req, input logic [7:0] b, input logic m,
                        input logic [15:0] off, input logic [7:0] stp);
        int cnt;
        if (m) cnt = $countones(b ^ exp_prev);
        else   cnt = 8 - $countones(b);
        in_valid = 1'b1; in_bus = b; in_mode = m; cfg_offset = off; cfg_step = stp;
        @(negedge clk);
        in_valid = 1'b0;
        exp_prev = b;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " count"}, int'(out_count), cnt);
        check({req, " sample R5"}, int'(out_sample), exp_sample(off, stp, cnt));
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 count", int'(out_count), 0);
        check("R1 sample", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: first switching sample compares against zeros
        send("R4", 8'hA7, 1'b1, 16'd100, 8'd13);

        // R6: no strobe the cycle after a lone sample
        @(negedge clk);
        check("R6 idle valid", int'(out_valid), 0);

        // R2: every bus value in the precharged model
        for (int v = 0; v < 256; v++) begin
            send("R2", 8'(v), 1'b0, 16'(v * 37), 8'(v ^ 8'h5A));
        end

        // R3 / R9: address then data pairs, switching model, back-to-back
        for (int a = 0; a < 256; a++) begin
            for (int d = 0; d < 256; d += 3) begin
                send("R9 addr", 8'(a), 1'b1, 16'd7, 8'd3);
                send("R3", 8'(d), 1'b1, 16'(a * 200), 8'(d));
            end
        end

        // R8: precharged sample becomes history for switching
        send("R8 pre", 8'h0F, 1'b0, 16'd0, 8'd1);
        send("R8", 8'hF0, 1'b1, 16'd0, 8'd1);

        // R7: idle inputs have no effect
        held = out_sample;
        in_valid = 1'b0; in_bus = 8'h00; in_mode = 1'b0; cfg_offset = 16'hFFFF; cfg_step = 8'hFF;
        repeat (4) @(negedge clk);
        check("R7 valid", int'(out_valid), 0);
        check("R7 sample", int'(out_sample), int'(held));
        check("R7 count", int'(out_count), 8);
        send("R7 history", 8'hF1, 1'b1, 16'd0, 8'd1); // one toggle against 0xF0

        // R5: exact limit and beyond
        send("R5 exact", 8'hFF, 1'b1, 16'(65535 - 8 * 255), 8'd255); // 0xF1->0xFF: 3 toggles
        send("R5 exact8", 8'h00, 1'b0, 16'(65535 - 8 * 255), 8'd255);
        send("R5 sat", 8'h00, 1'b0, 16'hFFF0, 8'd255);
        send("R5 zero step", 8'h00, 1'b0, 16'd1234, 8'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule